// File: doc/BRIEF.md
# Register-Window Processor Status Register

This block holds the 13-bit status word of a register-windowed RISC core. It keeps two circular 3-bit window pointers: the active window and the most recently saved window. It also holds an interrupt-enable flag, a system-mode flag with a shadow of its previous value, and the four condition codes.

On a procedure call the active pointer steps down by one. On a return it steps up by one. When the new active pointer lands on the saved pointer, the block raises a window overflow trap (on a call) or a window underflow trap (on a return). The trap handler reports each finished spill or fill so that the saved pointer can follow.

The block checks privilege. A privileged operation issued in user mode is flagged as illegal and has no effect. In system mode, software may replace the whole word in one cycle. Condition codes from the execute stage are latched only when the instruction requests it. Interrupt acceptance is gated by the enable flag, but a reset request is always accepted.

Top module: `pstat_reg`

## Requirements
- R1: After reset, `psw_o` reads 0x1CA0: active pointer 7, saved pointer 1, interrupts disabled, system mode set, previous-mode bit clear, and all condition codes clear. The bit layout is active pointer [12:10], saved pointer [9:7], interrupt enable [6], system mode [5], previous mode [4], Z [3], N [2], V [1], C [0].
- R2: When `call_i` is high alone, the active pointer decrements modulo 8. When `ret_i` is high alone, it increments modulo 8. When both are high, the pointer holds. The new value is visible on `psw_o` after the next rising clock edge.
- R3: When `spill_done_i` is high alone, the saved pointer increments modulo 8. When `fill_done_i` is high alone, it decrements modulo 8. When both are high, the pointer holds.
- R4: `ovf_trap_o` is high in the same cycle as a lone call whose new active pointer equals the saved pointer. `unf_trap_o` is high in the same cycle as a lone return whose new active pointer equals the saved pointer. Both are low in every other cycle.
- R5: `int_take_o` is high in the same cycle whenever `rst_req_i` is high, or whenever `irq_i` is high and interrupt enable is 1.
- R6: `illegal_o` is high in the same cycle whenever `priv_op_i` or `wr_en_i` is high while system mode is 0. In that case the whole-word write has no effect on `psw_o`.
- R7: Whenever the system-mode bit changes value, the previous-mode bit takes the value that system mode held just before the change.
- R8: The condition codes load from `cc_i` (ordered {Z,N,V,C}) only when `set_cc_i` is high. Otherwise they hold.
- R9: A whole-word write accepted in system mode loads `wr_data_i` into all 13 bits on the next edge. It overrides call, return, spill, fill and condition-code updates in the same cycle, and suppresses both window traps. The one exception is the previous-mode bit, which follows R7 when the written system-mode bit differs from the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure-call event |
| ret_i | input | 1 | Procedure-return event |
| spill_done_i | input | 1 | Trap handler finished saving a window |
| fill_done_i | input | 1 | Trap handler finished restoring a window |
| priv_op_i | input | 1 | A privileged instruction is issuing |
| wr_en_i | input | 1 | Whole-word write request (privileged) |
| wr_data_i | input | 13 | Word to write |
| set_cc_i | input | 1 | Instruction requests condition-code update |
| cc_i | input | 4 | Execute-stage flags {Z,N,V,C} |
| irq_i | input | 1 | Maskable interrupt request |
| rst_req_i | input | 1 | Non-maskable reset request |
| psw_o | output | 13 | Registered status word |
| ovf_trap_o | output | 1 | Window overflow trap (combinational) |
| unf_trap_o | output | 1 | Window underflow trap (combinational) |
| illegal_o | output | 1 | Illegal-opcode trap (combinational) |
| int_take_o | output | 1 | Interrupt accepted (combinational) |

## Verification
The trap, illegal and interrupt-accept flags depend only on the current inputs and state. The bench therefore samples them one nanosecond after it drives the inputs, in the same cycle. Every change to the status word appears on `psw_o` one rising edge later. For this reason the driver pushes each expected word into a queue, and a monitor pops it just after the next rising edge. The expected word comes from a separate model of the requirements.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
    localparam int WIN_W = 3;
    localparam int CC_W  = 4;
    localparam int PSW_W = 2 * WIN_W + 3 + CC_W;

    typedef struct packed {
        logic [WIN_W-1:0] cwp;
        logic [WIN_W-1:0] swp;
        logic             ien;
        logic             sys;
        logic             psys;
        logic [CC_W-1:0]  cc;   // {Z,N,V,C}
    } psw_t;

    localparam psw_t PSW_RST = '{
        cwp:  {WIN_W{1'b1}},
        swp:  WIN_W'(1),
        ien:  1'b0,
        sys:  1'b1,
        psys: 1'b0,
        cc:   '0
    };
endpackage

// File: rtl/pstat_win.sv
module pstat_win #(
    parameter int WIN_W = 3
) (
    input  logic [WIN_W-1:0] cwp_q,
    input  logic [WIN_W-1:0] swp_q,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             spill_i,
    input  logic             fill_i,
    input  logic             hold_i,
    output logic [WIN_W-1:0] cwp_d,
    output logic [WIN_W-1:0] swp_d,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    logic do_call, do_ret;

    always_comb begin
        do_call = call_i & ~ret_i & ~hold_i;
        do_ret  = ret_i & ~call_i & ~hold_i;

        cwp_d = cwp_q;
        if (do_call)     cwp_d = cwp_q - ONE;
        else if (do_ret) cwp_d = cwp_q + ONE;

        swp_d = swp_q;
        if (!hold_i) begin
            if (spill_i && !fill_i)      swp_d = swp_q + ONE;
            else if (fill_i && !spill_i) swp_d = swp_q - ONE;
        end

        ovf_o = do_call && (cwp_d == swp_q);
        unf_o = do_ret  && (cwp_d == swp_q);
    end
endmodule

// File: rtl/pstat_mode.sv
module pstat_mode
    import pstat_pkg::*;
(
    input  psw_t            psw_q,
    input  psw_t            wr_word_i,
    input  logic            wr_en_i,
    input  logic            priv_op_i,
    input  logic            set_cc_i,
    input  logic [CC_W-1:0] cc_i,
    input  logic            irq_i,
    input  logic            rst_req_i,
    output logic            wr_acc_o,
    output logic            ien_d,
    output logic            sys_d,
    output logic            psys_d,
    output logic [CC_W-1:0] cc_d,
    output logic            illegal_o,
    output logic            int_take_o
);
    always_comb begin
        wr_acc_o   = wr_en_i & psw_q.sys;
        illegal_o  = (priv_op_i | wr_en_i) & ~psw_q.sys;
        int_take_o = rst_req_i | (irq_i & psw_q.ien);

        ien_d  = psw_q.ien;
        sys_d  = psw_q.sys;
        psys_d = psw_q.psys;
        cc_d   = psw_q.cc;

        if (wr_acc_o) begin
            ien_d  = wr_word_i.ien;
            sys_d  = wr_word_i.sys;
            psys_d = (wr_word_i.sys != psw_q.sys) ? psw_q.sys : wr_word_i.psys;
            cc_d   = wr_word_i.cc;
        end else if (set_cc_i) begin
            cc_d = cc_i;
        end
    end
endmodule

// File: rtl/pstat_reg.sv
module pstat_reg
    import pstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             spill_done_i,
    input  logic             fill_done_i,
    input  logic             priv_op_i,
    input  logic             wr_en_i,
    input  logic [PSW_W-1:0] wr_data_i,
    input  logic             set_cc_i,
    input  logic [CC_W-1:0]  cc_i,
    input  logic             irq_i,
    input  logic             rst_req_i,
    output logic [PSW_W-1:0] psw_o,
    output logic             ovf_trap_o,
    output logic             unf_trap_o,
    output logic             illegal_o,
    output logic             int_take_o
);
    psw_t psw_q, psw_d, wr_word;
    logic wr_acc;
    logic [WIN_W-1:0] cwp_n, swp_n;
    logic ien_n, sys_n, psys_n;
    logic [CC_W-1:0] cc_n;

    assign wr_word = psw_t'(wr_data_i);

    pstat_win #(.WIN_W(WIN_W)) i_win (
        .cwp_q  (psw_q.cwp),
        .swp_q  (psw_q.swp),
        .call_i (call_i),
        .ret_i  (ret_i),
        .spill_i(spill_done_i),
        .fill_i (fill_done_i),
        .hold_i (wr_acc),
        .cwp_d  (cwp_n),
        .swp_d  (swp_n),
        .ovf_o  (ovf_trap_o),
        .unf_o  (unf_trap_o)
    );

    pstat_mode i_mode (
        .psw_q     (psw_q),
        .wr_word_i (wr_word),
        .wr_en_i   (wr_en_i),
        .priv_op_i (priv_op_i),
        .set_cc_i  (set_cc_i),
        .cc_i      (cc_i),
        .irq_i     (irq_i),
        .rst_req_i (rst_req_i),
        .wr_acc_o  (wr_acc),
        .ien_d     (ien_n),
        .sys_d     (sys_n),
        .psys_d    (psys_n),
        .cc_d      (cc_n),
        .illegal_o (illegal_o),
        .int_take_o(int_take_o)
    );

    always_comb begin
        psw_d      = psw_q;
        psw_d.cwp  = wr_acc ? wr_word.cwp : cwp_n;
        psw_d.swp  = wr_acc ? wr_word.swp : swp_n;
        psw_d.ien  = ien_n;
        psw_d.sys  = sys_n;
        psw_d.psys = psys_n;
        psw_d.cc   = cc_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psw_q <= PSW_RST;
        else        psw_q <= psw_d;
    end

    assign psw_o = psw_q;

    AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !(wr_en_i && psw_q.sys)) |=> (psw_q.cwp == $past(psw_q.cwp) - WIN_W'(1))); // R2
    AST_OVF_NEEDS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o |-> (call_i && !unf_trap_o)); // R4
    AST_RESET_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |-> int_take_o); // R5
    AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !psw_q.sys) |-> illegal_o); // R6
    AST_PREV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_q.sys != $past(psw_q.sys)) |-> (psw_q.psys == $past(psw_q.sys))); // R7
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_cc_i && !wr_en_i) |=> $stable(psw_q.cc)); // R8
endmodule

// File: tb/test_pstat_reg.sv
`timescale 1ns/100ps
module test_pstat_reg;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        call_i = 0, ret_i = 0, spill_done_i = 0, fill_done_i = 0;
    logic        priv_op_i = 0, wr_en_i = 0, set_cc_i = 0, irq_i = 0, rst_req_i = 0;
    logic [12:0] wr_data_i = '0;
    logic [3:0]  cc_i = '0;
    logic [12:0] psw_o;
    logic        ovf_trap_o, unf_trap_o, illegal_o, int_take_o;

    int n_chk = 0, n_fail = 0;
    logic [12:0] m;            // model of the status word
    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pstat_reg i_pstat_reg (.*);

    task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compare registered word just after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) chk(tag_q.pop_front(), psw_o, exp_q.pop_front());
    end

    task automatic step(input logic call, ret, spill, fill, priv, wr,
                        input logic [12:0] wd, input logic setcc,
                        input logic [3:0] cc, input logic irq, rreq,
                        input string tag);
        logic [2:0] cwp, swp, ncwp;
        logic s, acc, e_ovf, e_unf;
        logic [12:0] nx;
        @(negedge clk);
        call_i = call; ret_i = ret; spill_done_i = spill; fill_done_i = fill;
        priv_op_i = priv; wr_en_i = wr; wr_data_i = wd; set_cc_i = setcc;
        cc_i = cc; irq_i = irq; rst_req_i = rreq;
        #1;
        cwp = m[12:10]; swp = m[9:7]; s = m[5];
        acc = wr & s;
        ncwp = cwp;
        if (!acc && call && !ret) ncwp = cwp - 3'd1;
        if (!acc && ret && !call) ncwp = cwp + 3'd1;
        e_ovf = !acc && call && !ret && (ncwp == swp);
        e_unf = !acc && ret && !call && (ncwp == swp);
        chk({tag, " R4 ovf"}, 13'(ovf_trap_o), 13'(e_ovf));
        chk({tag, " R4 unf"}, 13'(unf_trap_o), 13'(e_unf));
        chk({tag, " R6 illegal"}, 13'(illegal_o), 13'((priv | wr) & ~s));
        chk({tag, " R5 take"}, 13'(int_take_o), 13'(rreq | (irq & m[6])));
        if (acc) begin
            nx = wd;
            if (wd[5] != s) nx[4] = s;           // R7
        end else begin
            nx = m;
            nx[12:10] = ncwp;
            if (spill && !fill) nx[9:7] = swp + 3'd1;
            if (fill && !spill) nx[9:7] = swp - 3'd1;
            if (setcc) nx[3:0] = cc;
        end
        m = nx;
        exp_q.push_back(nx);
        tag_q.push_back({tag, " word"});
    endtask

    task automatic idle(input string tag);
        step(0,0,0,0,0,0,'0,0,'0,0,0,tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        call_i = 0; ret_i = 0; spill_done_i = 0; fill_done_i = 0; priv_op_i = 0;
        wr_en_i = 0; set_cc_i = 0; irq_i = 0; rst_req_i = 0;
        @(negedge clk); @(negedge clk);
        exp_q.delete(); tag_q.delete();
        rst_n = 1;
        m = 13'h1CA0;
        chk("R1 reset value", psw_o, 13'h1CA0);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                n_fail++; n_chk++;
                $display("FAIL watchdog: actual expired expected done");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none
        do_reset();
        // R2 calls down to the collision, R4 overflow on 2->1
        for (int k = 0; k < 6; k++) step(1,0,0,0,0,0,'0,0,'0,0,0,"R2 call");
        step(1,0,0,0,0,0,'0,0,'0,0,0,"R2 wrap call");
        step(1,1,0,0,0,0,'0,0,'0,0,0,"R2 both");
        // R3 spill/fill
        step(0,0,1,0,0,0,'0,0,'0,0,0,"R3 spill");
        step(0,0,0,1,0,0,'0,0,'0,0,0,"R3 fill");
        step(0,0,1,1,0,0,'0,0,'0,0,0,"R3 both");
        for (int k = 0; k < 9; k++) step(0,1,0,0,0,0,'0,0,'0,0,0,"R2 ret");
        // R5 interrupt gating
        step(0,0,0,0,0,0,'0,0,'0,1,0,"R5 masked");
        step(0,0,0,0,0,0,'0,0,'0,0,1,"R5 reset req");
        // R8 condition codes
        step(0,0,0,0,0,0,'0,1,4'b1010,0,0,"R8 load");
        step(0,0,0,0,0,0,'0,0,4'b0101,0,0,"R8 hold");
        step(0,0,0,0,0,0,'0,1,4'b0001,0,0,"R8 load2");
        // R9 write beats call and cc, sets interrupts enable
        step(1,0,1,0,0,1,13'h0E75,1,4'b1111,1,0,"R9 write");
        step(0,0,0,0,0,0,'0,0,'0,1,0,"R5 enabled");
        // R7 write that clears system mode
        step(0,1,0,0,0,1,13'h0A45,0,'0,0,0,"R7 to user");
        // R6 user mode: privileged ops illegal, write ignored
        step(0,0,0,0,1,0,'0,0,'0,0,0,"R6 priv op");
        step(1,0,0,0,0,1,13'h1FFF,1,4'b0110,0,0,"R6 user write");
        idle("R6 after");
        do_reset();
        step(0,0,0,0,0,1,13'h1CE0,0,'0,0,0,"R9 same mode");
        idle("R1 idle");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule